// File: doc/BRIEF.md
# Signed Array Multiplier with Inverted-Bit Correction

This block multiplies two two's-complement operands of a configurable width and returns their full-width two's-complement product. Structurally it is the same uniform grid of AND gates and full adders that an unsigned array multiplier uses. Partial-product bits whose weight is negative are inverted rather than subtracted. Two fixed correction ones restore the exact signed result, so no sign-extension logic and no subtractor appear anywhere in the array.

The row built from the operand B sign bit consists almost entirely of inverted bits, and it is the last row to enter the carry-save chain. The inverted A-sign bits sit at the left edge of every row. The chain of full-adder rows ends in a ripple row with a complete carry chain, which resolves the upper product bits. A parameter can place a register with synchronous reset on the product, or leave the block purely combinational.

Top module: `bw_mult_top`

## Requirements
- R1: For every pair of WIDTH-bit two's-complement operands, `prod` equals their signed product as a 2*WIDTH-bit two's-complement value. WIDTH defaults to 8, and WIDTH=4 is supported as well.
- R2: The most negative value times itself gives exactly +2^(2*WIDTH-2). That is 16384 (0x4000) for WIDTH=8 and 64 (0x40) for WIDTH=4.
- R3: If either operand is zero, `prod` is zero.
- R4: An operand of +1 gives the other operand sign-extended to 2*WIDTH bits. An operand of -1 (all ones) gives its exact negation, so -1 times the most negative value is +2^(WIDTH-1).
- R5: When both operands are nonzero, the product's top bit `prod[2*WIDTH-1]` equals the XOR of the two operand sign bits.
- R6: With OUT_REG=1 (the default), `prod` takes the product of the operands sampled at a rising clock edge and keeps its previous value until that edge.
- R7: With OUT_REG=1, a high `rst` at a rising edge clears `prod` to zero, and the operands present during reset have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional product register |
| rst | input | 1 | Synchronous reset, active high |
| opnd_a | input | WIDTH | Multiplicand, two's complement |
| opnd_b | input | WIDTH | Multiplier, two's complement |
| prod | output | 2*WIDTH | Two's-complement product |

## Verification
In the default registered form, each product is due exactly one rising edge after its operands are applied. The bench drives operands on a falling edge and reads `prod` on the following falling edge, which is half a period after the register captures. For the latency requirement, the bench also reads `prod` just before that edge to confirm the old value is still held. The reset check holds nonzero operands through a reset edge and reads the cleared product one falling edge later.

// File: rtl/bw_pkg.sv
package bw_pkg;
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/bw_pp_row.sv
module bw_pp_row #(
  parameter int WIDTH = 8,
  parameter int ROW   = 0
) (
  input  logic [WIDTH-1:0]   x,
  input  logic               y_bit,
  output logic [2*WIDTH-1:0] row
);
  localparam int PW = 2 * WIDTH;

  for (genvar k = 0; k < PW; k++) begin : g_bit
    if (k >= ROW && k < ROW + WIDTH) begin : g_pp
      localparam int  COL = k - ROW;
      localparam bit  INV = (COL == WIDTH - 1) != (ROW == WIDTH - 1);
      if (INV) begin : g_neg
        assign row[k] = ~(x[COL] & y_bit);
      end else begin : g_pos
        assign row[k] = x[COL] & y_bit;
      end
    end else begin : g_zero
      assign row[k] = 1'b0;
    end
  end
endmodule

// File: rtl/bw_csa_row.sv
module bw_csa_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] in_s,
  input  logic [W-1:0] in_c,
  input  logic [W-1:0] in_p,
  output logic [W-1:0] out_s,
  output logic [W-1:0] out_c
);
  import bw_pkg::*;

  assign out_c[0] = 1'b0;
  for (genvar k = 0; k < W; k++) begin : g_fa
    assign out_s[k] = fa_sum(in_s[k], in_c[k], in_p[k]);
    if (k < W - 1) begin : g_cy
      assign out_c[k+1] = fa_carry(in_s[k], in_c[k], in_p[k]);
    end
  end
endmodule

// File: rtl/bw_ripple_row.sv
module bw_ripple_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] sum
);
  import bw_pkg::*;

  logic [W-1:0] chain;
  assign chain[0] = 1'b0;
  for (genvar k = 0; k < W; k++) begin : g_fa
    assign sum[k] = fa_sum(op_a[k], op_b[k], chain[k]);
    if (k < W - 1) begin : g_cy
      assign chain[k+1] = fa_carry(op_a[k], op_b[k], chain[k]);
    end
  end
endmodule

// File: rtl/bw_mult_top.sv
module bw_mult_top #(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH-1:0]   opnd_a,
  input  logic [WIDTH-1:0]   opnd_b,
  output logic [2*WIDTH-1:0] prod
);
  localparam int PW = 2 * WIDTH;
  localparam logic [PW-1:0] CORR = (PW'(1) << WIDTH) | (PW'(1) << (PW - 1));
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [PW-1:0] pp_rows [WIDTH];
  logic [PW-1:0] s_chain [WIDTH];
  logic [PW-1:0] c_chain [WIDTH];
  logic [PW-1:0] prod_comb;

  for (genvar j = 0; j < WIDTH; j++) begin : g_rows
    bw_pp_row #(.WIDTH(WIDTH), .ROW(j)) u_pp (
      .x(opnd_a), .y_bit(opnd_b[j]), .row(pp_rows[j])
    );
  end

  assign s_chain[0] = pp_rows[0];
  assign c_chain[0] = CORR;

  for (genvar j = 1; j < WIDTH; j++) begin : g_csa
    bw_csa_row #(.W(PW)) u_csa (
      .in_s(s_chain[j-1]), .in_c(c_chain[j-1]), .in_p(pp_rows[j]),
      .out_s(s_chain[j]), .out_c(c_chain[j])
    );
  end

  bw_ripple_row #(.W(PW)) u_final (
    .op_a(s_chain[WIDTH-1]), .op_b(c_chain[WIDTH-1]), .sum(prod_comb)
  );

  logic [WIDTH-1:0] a_ref, b_ref;

  if (OUT_REG) begin : g_reg
    logic [PW-1:0] prod_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        prod_q <= '0;
        a_ref  <= '0;
        b_ref  <= '0;
      end else begin
        prod_q <= prod_comb;
        a_ref  <= opnd_a;
        b_ref  <= opnd_b;
      end
    end
    assign prod = prod_q;

    assert_reset_clear_R7: assert property (@(posedge clk)
      rst |=> (prod == '0));
  end else begin : g_comb
    assign prod  = prod_comb;
    assign a_ref = opnd_a;
    assign b_ref = opnd_b;
  end

  logic signed [PW-1:0] ea, eb, ref_p;
  assign ea    = {{WIDTH{a_ref[WIDTH-1]}}, a_ref};
  assign eb    = {{WIDTH{b_ref[WIDTH-1]}}, b_ref};
  assign ref_p = ea * eb;

  assert_exact_R1: assert property (@(posedge clk) disable iff (rst)
    prod == ref_p);
  assert_min_square_R2: assert property (@(posedge clk) disable iff (rst)
    (a_ref == MOST_NEG && b_ref == MOST_NEG) |-> (prod == (PW'(1) << (PW - 2))));
  assert_zero_operand_R3: assert property (@(posedge clk) disable iff (rst)
    (a_ref == '0 || b_ref == '0) |-> (prod == '0));
  assert_unit_operand_R4: assert property (@(posedge clk) disable iff (rst)
    (a_ref == WIDTH'(1)) |-> (prod == eb));
  assert_sign_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (a_ref != '0 && b_ref != '0) |-> (prod[PW-1] == (a_ref[WIDTH-1] ^ b_ref[WIDTH-1])));
endmodule

// File: tb/tb_bw_mult_top.sv
module tb_bw_mult_top;
  localparam int N8 = 8;
  localparam int N4 = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N8-1:0] a8 = '0, b8 = '0;
  logic [N4-1:0] a4 = '0, b4 = '0;
  logic [2*N8-1:0] p8;
  logic [2*N4-1:0] p4;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bw_mult_top #(.WIDTH(N8), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst(rst), .opnd_a(a8), .opnd_b(b8), .prod(p8));
  bw_mult_top #(.WIDTH(N4), .OUT_REG(1'b1)) dut4 (
    .clk(clk), .rst(rst), .opnd_a(a4), .opnd_b(b4), .prod(p4));

  function automatic longint sprod(longint a, longint b, int n);
    longint sa, sb, mask;
    sa   = a[n-1] ? a - (longint'(1) << n) : a;
    sb   = b[n-1] ? b - (longint'(1) << n) : b;
    mask = (longint'(1) << (2 * n)) - 1;
    return (sa * sb) & mask;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run8(logic [N8-1:0] a, logic [N8-1:0] b, string req);
    @(negedge clk);
    a8 = a; b8 = b;
    @(negedge clk);
    chk(req, longint'(p8), sprod(longint'(a), longint'(b), N8));
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // R7: reset clears product although operands are nonzero
    a8 = 8'h7f; b8 = 8'h81; a4 = 4'h7; b4 = 4'h9;
    repeat (3) @(negedge clk);
    chk("R7 prod8 in reset", longint'(p8), 0);
    chk("R7 prod4 in reset", longint'(p4), 0);
    rst = 1'b0;

    // R3: zero operand
    run8(8'h00, 8'h5a, "R3");
    run8(8'h93, 8'h00, "R3");
    // R4: unit operands
    run8(8'h01, 8'h9c, "R4");
    run8(8'h6b, 8'h01, "R4");
    run8(8'hff, 8'h2d, "R4");
    run8(8'hff, 8'h80, "R4");
    // R2: most negative squared
    @(negedge clk); a8 = 8'h80; b8 = 8'h80;
    @(negedge clk); chk("R2 min*min", longint'(p8), 16384);
    // R1: extremes
    run8(8'h80, 8'h7f, "R1");
    run8(8'h7f, 8'h80, "R1");
    run8(8'h7f, 8'h7f, "R1");
    run8(8'hff, 8'hff, "R1");

    // R6: product held until the edge, then updated
    @(negedge clk); a8 = 8'h03; b8 = 8'h05;
    @(negedge clk); chk("R6 new value", longint'(p8), 15);
    a8 = 8'hfd; b8 = 8'h07;
    @(posedge clk); #1;
    @(negedge clk); chk("R6 after edge", longint'(p8), sprod(8'hfd, 8'h07, N8));
    a8 = 8'h11; b8 = 8'h02;
    #2 chk("R6 held before edge", longint'(p8), sprod(8'hfd, 8'h07, N8));
    @(negedge clk); chk("R6 updated", longint'(p8), 34);

    // R1/R2: exhaustive at width 4, including -8*-8 = 64
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        a4 = 4'(i); b4 = 4'(k);
        @(negedge clk);
        chk((i == 8 && k == 8) ? "R2 w4" : "R1 w4", longint'(p4),
            sprod(longint'(i), longint'(k), N4));
      end
    end

    // R1/R5: random pairs at width 8
    for (int t = 0; t < 2000; t++) begin
      logic [N8-1:0] ra, rb;
      ra = 8'($urandom);
      rb = 8'($urandom);
      run8(ra, rb, "R1 rand");
      if (ra != 0 && rb != 0)
        chk("R5 sign", longint'(p8[2*N8-1]), longint'(ra[N8-1] ^ rb[N8-1]));
    end

    // R7: reset mid-run clears product
    @(negedge clk); a8 = 8'h55; b8 = 8'h66; rst = 1'b1;
    @(negedge clk); chk("R7 mid reset", longint'(p8), 0);
    rst = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule